// File: doc/BRIEF.md
# Repeated-Subtraction Unsigned Divider

This block divides one unsigned integer by another over several clock cycles. Two operand registers, the dividend and the divisor, are written through parallel inputs, and each has its own load enable. When the start input is raised, the running remainder is seeded with the dividend and the quotient is cleared. Then, once per cycle, the divisor is taken away from the remainder and the quotient is counted up. This repeats until the remainder drops below the divisor. The number of cycles therefore depends on the data: it is the quotient plus a fixed overhead.

A three-state controller steps through idle, run and finished. The finished flag stays high for as long as start is held. The block goes back to idle only after start falls. A zero divisor takes a short path to the finished state and raises a separate flag, so it never loops without end.

Top module: `rsub_divider`

## Requirements
- R1: After the asynchronous active-low reset, `done`, `div_zero`, `quot` and `rem` are all zero.
- R2: An operand register is written only when the controller is idle, `start` is low and that operand's own load enable is high. A load enable raised in any other situation has no effect on the next result.
- R3: For a nonzero divisor B and a dividend A, the final outputs satisfy `quot`×B + `rem` = A and `rem` < B. This includes A < B, A = B, A = 0 and B = 1.
- R4: For a nonzero divisor, `done` rises exactly `quot`+2 clock edges after the edge that samples `start` high in idle. Each run cycle that subtracts adds exactly one to `quot`.
- R5: `quot` and `rem` keep their final values from the cycle `done` rises until the next start is accepted. This holds while `done` stays high and after the block has returned to idle.
- R6: While `start` stays high, `done` stays high. On the first edge that samples `start` low in the finished state, `done` falls.
- R7: With a zero divisor, `done` rises one edge after start is accepted. `quot` is then all ones, `rem` equals the dividend and `div_zero` is 1. The next accepted start with a nonzero divisor clears `div_zero`.
- R8: The worst case, dividend all ones and divisor 1, finishes with `quot` all ones and `rem` zero after 2^W+1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_a | input | 1 | Load enable for the dividend register |
| ld_b | input | 1 | Load enable for the divisor register |
| start | input | 1 | Begins an operation; must be released before the next one |
| dividend | input | W | Parallel dividend data |
| divisor | input | W | Parallel divisor data |
| quot | output | W | Quotient |
| rem | output | W | Remainder |
| done | output | 1 | High in the finished state |
| div_zero | output | 1 | The last operation had a zero divisor |

## Verification
The results come at different times:
- For a nonzero divisor, the quotient and remainder are due on the `quot`+2-th rising edge after the edge that samples `start`.
- For a zero divisor, they are due on the first such edge.
- `done` falls one edge after `start` is seen low.

The bench changes inputs on falling edges and counts falling edges from the one where it raised `start` until `done` is seen. The count must match the expected latency exactly. Only then does the bench compare the outputs. It samples them again several cycles later, and once more after the return to idle, to confirm they have not moved.

// File: rtl/rsub_divider.sv
module rsub_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         done,
  output logic         div_zero
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t          st;
  logic [W-1:0] a_q, b_q;
  logic [W:0]   diff;
  logic         fits;

  assign diff = {1'b0, rem} - {1'b0, b_q};
  assign fits = ~diff[W];
  assign done = (st == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (st == S_IDLE && !start) begin
      if (ld_a) a_q <= dividend;
      if (ld_b) b_q <= divisor;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      quot     <= '0;
      rem      <= '0;
      div_zero <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          rem      <= a_q;
          div_zero <= (b_q == '0);
          if (b_q == '0) begin
            quot <= '1;
            st   <= S_FIN;
          end else begin
            quot <= '0;
            st   <= S_RUN;
          end
        end
        S_RUN: if (fits) begin
          rem  <= diff[W-1:0];
          quot <= quot + 1'b1;
        end else begin
          st <= S_FIN;
        end
        S_FIN: if (!start) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  rem_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (rem < b_q));

  // R4
  quot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |=> ((st == S_RUN && quot == $past(quot) + 1'b1) || st == S_FIN));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN && !(st == S_IDLE && start)) |=> ($stable(quot) && $stable(rem)));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R7
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quot == {W{1'b1}} && rem == a_q));

endmodule

// File: tb/rsub_divider_tb.sv
module rsub_divider_tb;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 12;
  localparam logic [2*W-1:0] VEC [NV] = '{
    {8'd100, 8'd7},  {8'd7, 8'd100}, {8'd9, 8'd9},    {8'd0, 8'd5},
    {8'd255, 8'd1},  {8'd200, 8'd13},{8'd1, 8'd1},    {8'd0, 8'd1},
    {8'd128, 8'd255},{8'd255, 8'd16},{8'd254, 8'd255},{8'd64, 8'd2}
  };

  logic clk = 0, rst_n = 0, ld_a = 0, ld_b = 0, start = 0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic [W-1:0] quot, rem;
  logic done, div_zero;
  int checks = 0, errors = 0;

  rsub_divider #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_a(ld_a), .ld_b(ld_b), .start(start),
    .dividend(dividend), .divisor(divisor), .quot(quot), .rem(rem),
    .done(done), .div_zero(div_zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    dividend = a; divisor = b; ld_a = 1; ld_b = 1;
    @(negedge clk);
    ld_a = 0; ld_b = 0;
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    int cyc;
    logic [W-1:0] eq, er;
    int lat;
    eq  = (b == 0) ? {W{1'b1}} : a / b;
    er  = (b == 0) ? a : a % b;
    lat = (b == 0) ? 1 : int'(eq) + 2;
    start = 1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 1) begin
        dividend = ~a; divisor = b + 8'd3; ld_a = 1; ld_b = 1;
      end
    end while (!done && cyc < 600);
    ld_a = 0; ld_b = 0;
    chk("R4 latency", cyc, lat);
    chk("R3 quotient", quot, eq);
    chk("R3 remainder", rem, er);
    chk("R7 div_zero flag", div_zero, (b == 0));
    repeat (3) @(negedge clk);
    chk("R6 done held", done, 1);
    chk("R5 quot held", quot, eq);
    start = 0;
    @(negedge clk);
    chk("R6 done falls", done, 0);
    chk("R5 rem held in idle", rem, er);
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (2) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 div_zero", div_zero, 0);
    chk("R1 quot", quot, 0);
    chk("R1 rem", rem, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      load(VEC[i][2*W-1:W], VEC[i][W-1:0]);
      run(VEC[i][2*W-1:W], VEC[i][W-1:0], 0);
    end

    // R8 worst case
    load(8'hFF, 8'd1);
    run(8'hFF, 8'd1, 0);

    // R7 zero divisor, then cleared
    load(8'd77, 8'd0);
    run(8'd77, 8'd0, 0);
    load(8'd77, 8'd5);
    run(8'd77, 8'd5, 0);

    // R2 loads during run and finish are ignored
    load(8'd50, 8'd6);
    run(8'd50, 8'd6, 1);
    run(8'd50, 8'd6, 0);
    // R2 loads while start high in finish ignored
    start = 1;
    while (!done) @(negedge clk);
    dividend = 8'd3; divisor = 8'd1; ld_a = 1; ld_b = 1;
    @(negedge clk);
    ld_a = 0; ld_b = 0; start = 0;
    @(negedge clk);
    run(8'd50, 8'd6, 0);
    // R2 only the enabled operand loads
    @(negedge clk);
    dividend = 8'd91; divisor = 8'd200; ld_a = 1;
    @(negedge clk);
    ld_a = 0;
    run(8'd91, 8'd6, 0);

    lf = 16'hACE1;
    for (int k = 0; k < 24; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      load(lf[15:8], lf[7:0] | 8'd1);
      run(lf[15:8], lf[7:0] | 8'd1, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule